// File: doc/BRIEF.md
# SPI Master Transfer Engine

This block is the shift engine of a serial peripheral interface master. A single 32-bit configuration word selects the serial clock's idle level and its data phase, how many bits one character holds (8 to 16), the serial clock divisor, the delay from chip-select assertion to the first clock edge, and an idle gap after each character. The chip-select behaviour once a character is done is also part of that word.

A client presents a character, a target chip-select index and a "last character" flag, then pulses `start` while `busy` is low. The engine asserts the selected active-low chip-select line and waits the lead delay. It then toggles the serial clock twice per bit, shifting out MSB first while shifting in from the slave. It returns the received character right-justified with a one-cycle `rx_done` strobe. Chip select is then released or kept, depending on the hold and release controls and on the last flag. In hold mode the line stays low until a character is sent to a different slave.

Top module: `spi_xfer_engine`

## Requirements
- R1: Configuration bits 7:4 give the character length: codes 0..8 mean 8..16 bits, and codes 9..15 mean 16 bits. Each character produces exactly twice its length in serial clock edges, and `rx_data` holds the received bits right-justified with zeros above them.
- R2: Configuration bit 0 sets the serial clock idle level (0 low, 1 high). The clock is at that level after reset, between characters and in the cycle `rx_done` is high.
- R3: When configuration bit 1 is 0, MOSI changes on each leading edge and the data is sampled on the following edge. When it is 1, the data is sampled on the leading edge and MOSI changes on the trailing edge, with the first bit already driven in the cycle after `start` is accepted.
- R4: Bits 15:8 give the serial clock half-period in system clocks, and a value of 0 acts as 1.
- R5: The first serial clock edge comes N system clocks after `busy` rises, where N is bits 23:16. When that field is 0, N is the half-period.
- R6: After each character, `busy` stays high for 32 times bits 31:24 cycles, counting the `rx_done` cycle. When that field is 0, `busy` is low in the `rx_done` cycle.
- R7: Data is shifted MSB first on MOSI and assembled MSB first from MISO. `rx_done` is high for exactly one cycle per character.
- R8: With hold (bit 3) at 0, chip select is released in the `rx_done` cycle if the last flag was set or if bit 2 (release after each character) is 1. Otherwise the line stays low. Chip select is low while the clock is running.
- R9: With hold at 1, chip select stays low after the last character and does not rise for a following character to the same index. A character to a different index raises the old line in the same cycle the new one falls. At most one line is ever low.
- R10: A `start` pulse while `busy` is high is ignored: it starts no character and changes no output.
- R11: Reset (synchronous, active high) leaves all chip-select lines high, the clock low, `busy` and `rx_done` low and `rx_data` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 32 | Character configuration word, latched at `start` |
| start | input | 1 | Request a character; accepted when `busy` is low |
| tx_data | input | 16 | Character to send, right-justified |
| last_xfer | input | 1 | Marks the character as the last of a sequence |
| cs_sel | input | 2 | Target chip-select index |
| busy | output | 1 | Engine is running a character or its trailing gap |
| rx_data | output | 16 | Received character, right-justified |
| rx_done | output | 1 | One-cycle strobe: `rx_data` is valid |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| cs_n | output | 4 | Active-low chip-select lines |

## Verification
The embedded properties watch, on every cycle, the single-cycle `rx_done` strobe and the clock's return to its idle level by that strobe. They also watch the zero padding above the received character, the stillness of MOSI across sampling edges, chip select held low while the clock runs, and the at-most-one-low rule across chip-select lines. The measured timing can only be seen in the bench's scenarios: lead delay, half-period, gap length, edge count and the exact bit order on the wire, seen through a MOSI-to-MISO loopback with optional inversion. The same holds for the hold and release rules of chip select across sequences of characters and for a start pulse that arrives while busy.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

    localparam int CFG_W    = 32;
    localparam int MAX_BITS = 16;
    localparam int LEN_W    = $clog2(MAX_BITS) + 1;
    localparam int EIDX_W   = LEN_W + 1;
    localparam int GAP_SH   = 5;
    localparam int CNT_W    = 8 + GAP_SH;

    // Field layout of the configuration word (bit positions are fixed by behaviour)
    typedef struct packed {
        logic [7:0] gap_units;
        logic [7:0] lead_dly;
        logic [7:0] divisor;
        logic [3:0] len_code;
        logic       hold_cs;
        logic       drop_cs;
        logic       lead_capture;
        logic       idle_high;
    } cfg_fields_t;

    // Decoded plan for one character
    typedef struct packed {
        logic             idle_high;
        logic             lead_capture;
        logic             hold_cs;
        logic             drop_cs;
        logic [LEN_W-1:0] nbits;
        logic [7:0]       half;
        logic [7:0]       lead;
        logic [CNT_W-1:0] gap;
    } xfer_plan_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TAIL,
        ST_GAP
    } seq_state_t;

    function automatic logic [LEN_W-1:0] char_len(input logic [3:0] code);
        return (code > 4'd8) ? LEN_W'(MAX_BITS) : LEN_W'(code) + LEN_W'(8);
    endfunction

endpackage

// File: rtl/spi_cfg_decode.sv
module spi_cfg_decode
    import spi_xfer_pkg::*;
(
    input  logic [CFG_W-1:0] word,
    output xfer_plan_t       plan
);
    cfg_fields_t f;
    logic [7:0]  half_eff;

    assign f        = cfg_fields_t'(word);
    assign half_eff = (f.divisor == 8'd0) ? 8'd1 : f.divisor;

    always_comb begin
        plan.idle_high    = f.idle_high;
        plan.lead_capture = f.lead_capture;
        plan.hold_cs      = f.hold_cs;
        plan.drop_cs      = f.drop_cs;
        plan.nbits        = char_len(f.len_code);
        plan.half         = half_eff;
        plan.lead         = (f.lead_dly == 8'd0) ? half_eff : f.lead_dly;
        plan.gap          = {f.gap_units, {GAP_SH{1'b0}}};
    end
endmodule

// File: rtl/spi_bit_shifter.sv
module spi_bit_shifter
    import spi_xfer_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [MAX_BITS-1:0] load_data,
    input  logic [LEN_W-1:0]    nbits,
    input  logic                lead_capture,
    input  logic                drive,
    input  logic                sample,
    input  logic                miso,
    output logic                mosi,
    output logic [MAX_BITS-1:0] rx_word
);
    logic [MAX_BITS-1:0] tsr;
    logic [MAX_BITS-1:0] rsr;
    logic [LEN_W-1:0]    pad;
    logic [MAX_BITS-1:0] aligned;

    assign pad     = LEN_W'(MAX_BITS) - nbits;
    assign aligned = load_data << pad;
    assign rx_word = rsr;

    always_ff @(posedge clk) begin
        if (rst) begin
            tsr  <= '0;
            rsr  <= '0;
            mosi <= 1'b0;
        end else if (load) begin
            mosi <= aligned[MAX_BITS-1];
            tsr  <= lead_capture ? (aligned << 1) : aligned;
            rsr  <= '0;
        end else begin
            if (drive) begin
                mosi <= tsr[MAX_BITS-1];
                tsr  <= tsr << 1;
            end
            if (sample) begin
                rsr <= {rsr[MAX_BITS-2:0], miso};
            end
        end
    end

    AST_NO_CLASH: assert property (@(posedge clk) disable iff (rst)
        !(drive && sample)); // R3
endmodule

// File: rtl/spi_cs_ctrl.sv
module spi_cs_ctrl #(
    parameter  int NUM_CS = 4,
    localparam int CS_IW  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             grab,
    input  logic [CS_IW-1:0] grab_idx,
    input  logic             release_now,
    output logic [NUM_CS-1:0] cs_n
);
    for (genvar i = 0; i < NUM_CS; i++) begin : g_line
        logic line_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                line_q <= 1'b1;
            end else if (grab) begin
                line_q <= (grab_idx != CS_IW'(i));
            end else if (release_now) begin
                line_q <= 1'b1;
            end
        end
        assign cs_n[i] = line_q;
    end

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
        $countones(~cs_n) <= 1); // R9
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
    import spi_xfer_pkg::*;
#(
    parameter  int NUM_CS = 4,
    localparam int CS_IW  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CFG_W-1:0]    cfg_word,
    input  logic                start,
    input  logic [MAX_BITS-1:0] tx_data,
    input  logic                last_xfer,
    input  logic [CS_IW-1:0]    cs_sel,
    output logic                busy,
    output logic [MAX_BITS-1:0] rx_data,
    output logic                rx_done,
    output logic                sck,
    output logic                mosi,
    input  logic                miso,
    output logic [NUM_CS-1:0]   cs_n
);
    xfer_plan_t          dec_plan;
    xfer_plan_t          plan;
    seq_state_t          state;
    logic [CNT_W-1:0]    cnt;
    logic [EIDX_W-1:0]   eidx;
    logic [EIDX_W-1:0]   last_edge;
    logic                last_q;
    logic                sck_q;
    logic                accept;
    logic                edge_now;
    logic                leading;
    logic                sample_now;
    logic                drive_now;
    logic                tail_end;
    logic                release_now;
    logic [MAX_BITS-1:0] rx_word;

    spi_cfg_decode u_dec (
        .word (cfg_word),
        .plan (dec_plan)
    );

    assign accept      = start && (state == ST_IDLE);
    assign edge_now    = ((state == ST_LEAD) || (state == ST_SHIFT)) && (cnt == '0);
    assign leading     = (sck_q == plan.idle_high);
    assign sample_now  = edge_now && (leading == plan.lead_capture);
    assign drive_now   = edge_now && (leading != plan.lead_capture);
    assign tail_end    = (state == ST_TAIL) && (cnt == '0);
    assign release_now = tail_end && !plan.hold_cs && (last_q || plan.drop_cs);
    assign last_edge   = {plan.nbits, 1'b0} - EIDX_W'(1);
    assign busy        = (state != ST_IDLE);
    assign sck         = sck_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            plan    <= '0;
            cnt     <= '0;
            eidx    <= '0;
            last_q  <= 1'b0;
            sck_q   <= 1'b0;
            rx_done <= 1'b0;
            rx_data <= '0;
        end else begin
            rx_done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    sck_q <= cfg_word[0];
                    if (start) begin
                        plan   <= dec_plan;
                        last_q <= last_xfer;
                        sck_q  <= dec_plan.idle_high;
                        cnt    <= CNT_W'(dec_plan.lead) - CNT_W'(1);
                        eidx   <= '0;
                        state  <= ST_LEAD;
                    end
                end
                ST_LEAD: begin
                    if (cnt == '0) begin
                        sck_q <= ~sck_q;
                        eidx  <= EIDX_W'(1);
                        cnt   <= CNT_W'(plan.half) - CNT_W'(1);
                        state <= ST_SHIFT;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                ST_SHIFT: begin
                    if (cnt == '0) begin
                        sck_q <= ~sck_q;
                        cnt   <= CNT_W'(plan.half) - CNT_W'(1);
                        if (eidx == last_edge) begin
                            state <= ST_TAIL;
                        end else begin
                            eidx <= eidx + EIDX_W'(1);
                        end
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                ST_TAIL: begin
                    if (cnt == '0) begin
                        rx_done <= 1'b1;
                        rx_data <= rx_word;
                        if (plan.gap != '0) begin
                            cnt   <= plan.gap - CNT_W'(1);
                            state <= ST_GAP;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                ST_GAP: begin
                    if (cnt == '0) begin
                        state <= ST_IDLE;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    spi_bit_shifter u_shift (
        .clk          (clk),
        .rst          (rst),
        .load         (accept),
        .load_data    (tx_data),
        .nbits        (dec_plan.nbits),
        .lead_capture (dec_plan.lead_capture),
        .drive        (drive_now),
        .sample       (sample_now),
        .miso         (miso),
        .mosi         (mosi),
        .rx_word      (rx_word)
    );

    spi_cs_ctrl #(.NUM_CS(NUM_CS)) u_cs (
        .clk         (clk),
        .rst         (rst),
        .grab        (accept),
        .grab_idx    (cs_sel),
        .release_now (release_now),
        .cs_n        (cs_n)
    );

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rx_done |=> !rx_done); // R7
    AST_SCK_HOME: assert property (@(posedge clk) disable iff (rst)
        rx_done |-> (sck == plan.idle_high)); // R2
    AST_RX_JUSTIFIED: assert property (@(posedge clk) disable iff (rst)
        rx_done |-> ((rx_data >> plan.nbits) == '0)); // R1
    AST_MOSI_STEADY: assert property (@(posedge clk) disable iff (rst)
        sample_now |=> $stable(mosi)); // R3
    AST_CS_DURING_CLOCK: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SHIFT) |-> !(&cs_n)); // R8
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (start && (state == ST_SHIFT)) |=> $stable(cs_n)); // R10
endmodule

// File: tb/sim_spi_xfer_engine.sv
module sim_spi_xfer_engine;
    import spi_xfer_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cfg_word = '0;
    logic        start = 1'b0;
    logic [15:0] tx_data = '0;
    logic        last_xfer = 1'b0;
    logic [1:0]  cs_sel = '0;
    logic        busy;
    logic [15:0] rx_data;
    logic        rx_done;
    logic        sck;
    logic        mosi;
    logic        miso;
    logic [3:0]  cs_n;
    logic        miso_inv = 1'b0;

    always #2 clk = ~clk;
    assign miso = mosi ^ miso_inv;

    spi_xfer_engine #(.NUM_CS(4)) u0 (
        .clk(clk), .rst(rst), .cfg_word(cfg_word), .start(start),
        .tx_data(tx_data), .last_xfer(last_xfer), .cs_sel(cs_sel),
        .busy(busy), .rx_data(rx_data), .rx_done(rx_done), .sck(sck),
        .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    int n_cmp = 0;
    int n_bad = 0;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Wire monitor, sampled on the falling clock edge
    logic        prev_sck = 1'b0;
    logic        prev_busy = 1'b0;
    logic        mon_pol = 1'b0;
    logic        mon_pha = 1'b0;
    logic [15:0] mon_bits = '0;
    logic        cs1_high_seen = 1'b0;
    int cyc = 0, edges = 0, lead_meas = 0, last_edge_cyc = 0;
    int half_min = 0, half_max = 0;

    always @(negedge clk) begin
        if (busy && !prev_busy) begin
            cyc = 0; edges = 0; lead_meas = -1;
            half_min = 99999; half_max = 0; mon_bits = '0;
            mon_pol = cfg_word[0]; mon_pha = cfg_word[1];
        end else begin
            cyc++;
            if (busy && (sck !== prev_sck)) begin
                if (edges == 0) lead_meas = cyc;
                else begin
                    if (cyc - last_edge_cyc < half_min) half_min = cyc - last_edge_cyc;
                    if (cyc - last_edge_cyc > half_max) half_max = cyc - last_edge_cyc;
                end
                last_edge_cyc = cyc;
                if ((prev_sck == mon_pol) == mon_pha) mon_bits = {mon_bits[14:0], mosi};
                edges++;
            end
        end
        if (cs_n[1]) cs1_high_seen = 1'b1;
        prev_sck = sck;
        prev_busy = busy;
    end

    // Results of the last character
    logic [15:0] got_rx;
    logic [3:0]  done_cs, start_cs;
    logic        sck_at_done, strobe_after, start_mosi;
    int          gapc;

    task automatic do_xfer(input logic [31:0] cfg, input logic [15:0] data,
                           input logic last, input logic [1:0] idx, input logic inv);
        int t;
        @(negedge clk);
        cfg_word = cfg; tx_data = data; last_xfer = last; cs_sel = idx; miso_inv = inv;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        start_cs = cs_n;
        start_mosi = mosi;
        t = 0;
        while (!rx_done && t < 20000) begin
            @(negedge clk);
            t++;
        end
        got_rx = rx_data;
        done_cs = cs_n;
        sck_at_done = sck;
        gapc = busy ? 1 : 0;
        @(negedge clk);
        strobe_after = rx_done;
        while (busy && gapc < 20000) begin
            gapc++;
            @(negedge clk);
        end
    endtask

    function automatic int exp_len(input logic [3:0] code);
        return (code > 4'd8) ? 16 : int'(code) + 8;
    endfunction

    function automatic int exp_half(input logic [7:0] dv);
        return (dv == 8'd0) ? 1 : int'(dv);
    endfunction

    // {cfg_word, tx_data, miso inversion}
    localparam logic [48:0] VEC [0:5] = '{
        {32'h00000200, 16'h00A5, 1'b0},
        {32'h01050341, 16'h0ABC, 1'b1},
        {32'h00000182, 16'hC3A5, 1'b0},
        {32'h000300C3, 16'h8001, 1'b1},
        {32'h02020412, 16'hFF5A, 1'b0},
        {32'h00010271, 16'h1234, 1'b0}
    };

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check("R11", "cs_n", 32'(cs_n), 32'hF);
        check("R11", "sck", 32'(sck), 32'h0);
        check("R11", "busy", 32'(busy), 32'h0);
        check("R11", "rx_done", 32'(rx_done), 32'h0);
        check("R11", "rx_data", 32'(rx_data), 32'h0);

        // Table of configurations, each a stand-alone last character
        for (int i = 0; i < 6; i++) begin
            logic [31:0] c;
            logic [15:0] d, mask, exp_rx;
            logic        inv;
            int          n, h, ld;
            c = VEC[i][48:17];
            d = VEC[i][16:1];
            inv = VEC[i][0];
            n = exp_len(c[7:4]);
            h = exp_half(c[15:8]);
            ld = (c[23:16] == 8'd0) ? h : int'(c[23:16]);
            mask = 16'((32'h1 << n) - 1);
            exp_rx = (d ^ (inv ? 16'hFFFF : 16'h0000)) & mask;
            do_xfer(c, d, 1'b1, 2'd0, inv);
            check("R1", "rx_data", 32'(got_rx), 32'(exp_rx));
            check("R1", "edge count", 32'(edges), 32'(2 * n));
            check("R7", "mosi bits msb first", 32'(mon_bits & mask), 32'(d & mask));
            check("R4", "half period min", 32'(half_min), 32'(h));
            check("R4", "half period max", 32'(half_max), 32'(h));
            check("R5", "lead delay", 32'(lead_meas), 32'(ld));
            check("R6", "gap cycles", 32'(gapc), 32'(32 * int'(c[31:24])));
            check("R2", "sck idle at done", 32'(sck_at_done), 32'(c[0]));
            check("R7", "done strobe one cycle", 32'(strobe_after), 32'h0);
            check("R8", "cs released after last", 32'(done_cs), 32'hF);
            if (c[1]) check("R3", "first bit before first edge", 32'(start_mosi), 32'(d[n-1]));
        end

        // R8: no hold, not last, no per-character release -> stays low
        do_xfer(32'h00000200, 16'h0011, 1'b0, 2'd3, 1'b0);
        check("R8", "cs kept without last", 32'(done_cs), 32'h7);
        do_xfer(32'h00000200, 16'h0022, 1'b1, 2'd3, 1'b0);
        check("R8", "cs released on last", 32'(done_cs), 32'hF);
        // R8: release after every character
        do_xfer(32'h00000204, 16'h0033, 1'b0, 2'd0, 1'b0);
        check("R8", "cs released each character", 32'(done_cs), 32'hF);

        // R9: hold mode
        do_xfer(32'h00000208, 16'h005A, 1'b1, 2'd1, 1'b0);
        check("R9", "cs held after last", 32'(done_cs), 32'hD);
        repeat (5) @(negedge clk);
        check("R9", "cs still held", 32'(cs_n), 32'hD);
        cs1_high_seen = 1'b0;
        do_xfer(32'h00000208, 16'h003C, 1'b1, 2'd1, 1'b0);
        check("R9", "no rise on same index", 32'(cs1_high_seen), 32'h0);
        check("R7", "rx in hold mode", 32'(got_rx), 32'h3C);
        do_xfer(32'h00000208, 16'h0096, 1'b1, 2'd2, 1'b0);
        check("R9", "switch to new index", 32'(start_cs), 32'hB);
        do_xfer(32'h00000200, 16'h0001, 1'b1, 2'd2, 1'b0);
        check("R8", "release after hold cleared", 32'(done_cs), 32'hF);

        // R10: start while busy is ignored
        begin
            int pulses;
            @(negedge clk);
            cfg_word = 32'h00000300; tx_data = 16'h0081; last_xfer = 1'b1;
            cs_sel = 2'd0; miso_inv = 1'b0;
            @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (8) @(negedge clk);
            tx_data = 16'h007E;
            cs_sel = 2'd2;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check("R10", "cs unchanged by ignored start", 32'(cs_n), 32'hE);
            pulses = 0;
            for (int k = 0; k < 200; k++) begin
                if (rx_done) begin
                    pulses++;
                    check("R10", "rx of first character", 32'(rx_data), 32'h81);
                end
                @(negedge clk);
            end
            check("R10", "one character only", 32'(pulses), 32'h1);
            check("R10", "idle afterwards", 32'(busy), 32'h0);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule